// File: doc/BRIEF.md
# Memory-Mapped GPIO with Edge Capture

This peripheral serves up to 32 general-purpose pins through four word-wide registers on a simple read/write bus. Software sets each pin's output level and drive enable, reads the pin levels back, and takes per-pin interrupts. The pad side has three vectors: sampled inputs, output values and output enables. Tri-state pad cells are outside the block.

Every input passes through a two-flop synchronizer. The synchronized value feeds both the data readback and a per-pin edge detector. The trigger type is chosen when the block is built: rising edge, falling edge, both edges, or level high. It cannot be changed at run time.

In the three edge modes, detected edges latch into a capture register, and the interrupt line stays high while any captured bit is also enabled in the mask. Software clears captured bits by writing ones to them. In level mode the capture register stays idle. The interrupt then follows the masked synchronized input directly.

Top module: `gpio_edge_top`

## Requirements
- R1: After a synchronous reset, the output values, output enables, mask, capture bits and interrupt are all zero.
- R2: The direction register is at byte offset 0x4. Bit n set to 1 drives pad_oe[n] high, making pin n an output. The register reads back as written.
- R3: A write to the data register at offset 0x0 sets pad_out on the next clock edge. A read of offset 0x0 returns the synchronized pad_in, which reflects a pin change two clock edges after it happens.
- R4: In rising mode, a 0-to-1 change on a synchronized input sets that pin's capture bit (offset 0xC), and a 1-to-0 change does not.
- R5: In falling mode, only a 1-to-0 change sets the capture bit.
- R6: In both-edges mode, either change sets the capture bit.
- R7: Writing 1 to a capture bit clears it. Writing 0 leaves it unchanged. A capture bit sets only on a detected edge.
- R8: When an edge is detected on a pin in the same cycle that a write clears that pin's capture bit, the capture bit ends up 1.
- R9: The mask register is at offset 0x8, and a 1 enables that pin. In edge modes, irq is high exactly when the capture bits ANDed with the mask are nonzero.
- R10: In level mode, irq is high exactly when the synchronized inputs ANDed with the mask are nonzero, and the capture register stays zero.
- R11: Register bits at or above the pin count read as zero and ignore writes. The pin count is at most 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset; bits 3:2 select the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NPINS | Raw pin inputs |
| pad_out | output | NPINS | Output values |
| pad_oe | output | NPINS | Output enables |
| irq | output | 1 | Interrupt request |

## Verification
The capture register can be cleared by a bus write and set by a detected edge in the same clock. To provoke this, the bench raises an input and then times a write-one-to-clear so that the write lands on the exact edge where the synchronized change is seen. Reading the capture register afterwards must return the bit as set. Random pin patterns, random clears and random masks are also checked against a bench model of all four trigger modes running side by side.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int MAX_PINS = 32;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 4;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_MASK = 2'd2,
        REG_CAP  = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
        return reg_sel_e'(addr[3:2]);
    endfunction

    function automatic logic trig_is_edge(input trig_e t);
        return t != TRIG_LEVEL;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
    import gpio_edge_pkg::*;
#(
    parameter int    W       = 32,
    parameter trig_e TRIGGER = TRIG_BOTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    if (TRIGGER == TRIG_RISE) begin : g_rise
        assign evt = din & ~prev_q;
    end else if (TRIGGER == TRIG_FALL) begin : g_fall
        assign evt = ~din & prev_q;
    end else if (TRIGGER == TRIG_BOTH) begin : g_both
        assign evt = din ^ prev_q;
    end else begin : g_level
        assign evt = '0;
    end
endmodule

// File: rtl/gpio_capture.sv
module gpio_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] cap
);
    logic [W-1:0] clr_eff;
    logic [W-1:0] cap_d;

    always_comb begin
        clr_eff = clr_en ? clr_vec : '0;
        // a fresh edge outranks a clear landing in the same cycle
        cap_d   = (cap & ~clr_eff) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) cap <= '0;
        else     cap <= cap_d;
    end

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((cap & $past(set_vec)) == $past(set_vec)));

    a_r7_clear_by_one: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((cap & $past(clr_vec) & ~$past(set_vec)) == '0));

    a_r7_set_only_on_edge: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cap & ~$past(cap) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/gpio_edge_top.sv
module gpio_edge_top
    import gpio_edge_pkg::*;
#(
    parameter int    NPINS       = 32,
    parameter trig_e TRIGGER     = TRIG_BOTH,
    parameter int    SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    localparam logic IS_EDGE = trig_is_edge(TRIGGER);

    reg_sel_e         sel;
    logic [NPINS-1:0] wr_val;
    logic [NPINS-1:0] dout_q, dir_q, mask_q;
    logic [NPINS-1:0] sync_in, evt, cap;
    logic             cap_clr;

    assign sel     = decode_sel(bus_addr);
    assign wr_val  = bus_wdata[NPINS-1:0];
    assign cap_clr = bus_wr && (sel == REG_CAP);

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(pad_in), .dout(sync_in)
    );

    gpio_edge_det #(.W(NPINS), .TRIGGER(TRIGGER)) u_edge (
        .clk(clk), .rst(rst), .din(sync_in), .evt(evt)
    );

    gpio_capture #(.W(NPINS)) u_cap (
        .clk(clk), .rst(rst), .set_vec(evt),
        .clr_en(cap_clr), .clr_vec(wr_val), .cap(cap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                REG_DATA: dout_q <= wr_val;
                REG_DIR:  dir_q  <= wr_val;
                REG_MASK: mask_q <= wr_val;
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_DATA: bus_rdata[NPINS-1:0] = sync_in;
            REG_DIR:  bus_rdata[NPINS-1:0] = dir_q;
            REG_MASK: bus_rdata[NPINS-1:0] = mask_q;
            REG_CAP:  bus_rdata[NPINS-1:0] = cap;
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out = dout_q;
    assign pad_oe  = dir_q;

    if (IS_EDGE) begin : g_irq_edge
        assign irq = |(cap & mask_q);
        a_r9_irq_from_capture: assert property (@(posedge clk) disable iff (rst)
            irq |-> (cap != '0));
    end else begin : g_irq_level
        assign irq = |(sync_in & mask_q);
        a_r10_capture_idle: assert property (@(posedge clk) disable iff (rst)
            cap == '0);
    end

    a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_q != '0));

    a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == REG_DIR) |=> (pad_oe == $past(bus_wdata[NPINS-1:0])));

    a_r3_out_follows_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == REG_DATA) |=> (pad_out == $past(bus_wdata[NPINS-1:0])));

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (64'(bus_rdata) >> NPINS) == 64'd0);
endmodule

// File: tb/gpio_edge_top_tb.sv
module gpio_edge_top_tb;
    import gpio_edge_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] rd_both, rd_rise, rd_fall, rd_lvl;
    logic [23:0] out_both, oe_both;
    logic [7:0]  out_rise, oe_rise, out_fall, oe_fall, out_lvl, oe_lvl;
    logic        irq_both, irq_rise, irq_fall, irq_lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic [31:0] m_pad = '0, m_mask = '0;
    logic [31:0] m_cap_both = '0, m_cap_rise = '0, m_cap_fall = '0;

    always #5 clk = ~clk;

    gpio_edge_top #(.NPINS(24), .TRIGGER(TRIG_BOTH)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_both), .pad_in(pad_in[23:0]), .pad_out(out_both), .pad_oe(oe_both), .irq(irq_both));
    gpio_edge_top #(.NPINS(8), .TRIGGER(TRIG_RISE)) u_rise (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_rise), .pad_in(pad_in[7:0]), .pad_out(out_rise), .pad_oe(oe_rise), .irq(irq_rise));
    gpio_edge_top #(.NPINS(8), .TRIGGER(TRIG_FALL)) u_fall (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_fall), .pad_in(pad_in[7:0]), .pad_out(out_fall), .pad_oe(oe_fall), .irq(irq_fall));
    gpio_edge_top #(.NPINS(8), .TRIGGER(TRIG_LEVEL)) u_lvl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_lvl), .pad_in(pad_in[7:0]), .pad_out(out_lvl), .pad_oe(oe_lvl), .irq(irq_lvl));

    function automatic logic [31:0] edges(input int mode, input logic [31:0] o, input logic [31:0] n);
        case (mode)
            0:       return n & ~o;
            1:       return o & ~n;
            default: return o ^ n;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] b, output logic [31:0] r,
                            output logic [31:0] f, output logic [31:0] l);
        @(negedge clk);
        bus_addr = a;
        #1;
        b = rd_both; r = rd_rise; f = rd_fall; l = rd_lvl;
    endtask

    task automatic drive_pad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        m_cap_both |= edges(2, m_pad, v) & 32'h00FF_FFFF;
        m_cap_rise |= edges(0, m_pad, v) & 32'h0000_00FF;
        m_cap_fall |= edges(1, m_pad, v) & 32'h0000_00FF;
        m_pad = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_caps(input logic [31:0] v);
        bus_write(4'hC, v);
        m_cap_both &= ~v; m_cap_rise &= ~v; m_cap_fall &= ~v;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] b, r, f, l;
        bus_read(4'hC, b, r, f, l);
        chk({tag, " R6 both capture"}, b, m_cap_both);
        chk({tag, " R4 rise capture"}, r, m_cap_rise);
        chk({tag, " R5 fall capture"}, f, m_cap_fall);
        chk({tag, " R10 level capture idle"}, l, 32'h0);
        bus_read(4'h0, b, r, f, l);
        chk({tag, " R3 data readback"}, b, m_pad & 32'h00FF_FFFF);
        chk({tag, " R9 irq both"}, 32'(irq_both), 32'(|(m_cap_both & m_mask & 32'h00FF_FFFF)));
        chk({tag, " R9 irq rise"}, 32'(irq_rise), 32'(|(m_cap_rise & m_mask & 32'hFF)));
        chk({tag, " R10 irq level"}, 32'(irq_lvl), 32'(|(m_pad & m_mask & 32'hFF)));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired got=hung exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] b, r, f, l;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 pad_out", 32'(out_both), 32'h0);
        chk("R1 pad_oe", 32'(oe_both), 32'h0);
        chk("R1 irq", 32'({irq_both, irq_rise, irq_fall, irq_lvl}), 32'h0);
        bus_read(4'h8, b, r, f, l);
        chk("R1 mask", b, 32'h0);
        bus_read(4'hC, b, r, f, l);
        chk("R1 capture", b, 32'h0);

        // R2 direction, R11 upper bits
        bus_write(4'h4, 32'hFFFF_FFFF);
        chk("R2 pad_oe all", 32'(oe_both), 32'h00FF_FFFF);
        bus_read(4'h4, b, r, f, l);
        chk("R11 dir upper bits zero", b, 32'h00FF_FFFF);
        chk("R11 dir narrow instance", r, 32'h0000_00FF);
        bus_write(4'h4, 32'h0000_A5A5);
        chk("R2 pad_oe pattern", 32'(oe_both), 32'h0000_A5A5);

        // R3 data out
        bus_write(4'h0, 32'hAB12_3456);
        chk("R3 pad_out", 32'(out_both), 32'h0012_3456);
        chk("R11 pad_out narrow", 32'(out_rise), 32'h0000_0056);

        // R3 readback latency: two edges
        @(negedge clk);
        pad_in = 32'h0000_0001;
        @(negedge clk);
        bus_addr = 4'h0; #1;
        chk("R3 readback not yet", rd_both, 32'h0);
        @(negedge clk); #1;
        chk("R3 readback after two edges", rd_both, 32'h1);
        m_cap_both |= 32'h1; m_cap_rise |= 32'h1; m_pad = 32'h1;
        repeat (3) @(negedge clk);
        check_all("directed");

        // R7 writing zero leaves capture
        bus_write(4'hC, 32'h0);
        bus_read(4'hC, b, r, f, l);
        chk("R7 zero write keeps capture", b, m_cap_both);
        clear_caps(32'hFFFF_FFFF);
        check_all("R7 clear all");

        // random traffic
        for (int i = 0; i < 60; i++) begin
            drive_pad($urandom);
            if ((i % 3) == 0) begin
                m_mask = $urandom;
                bus_write(4'h8, m_mask);
                m_mask &= 32'h00FF_FFFF;
            end
            check_all("random");
            if ((i % 2) == 1) begin
                clear_caps($urandom);
                check_all("random R7 clear");
            end
        end

        // R8: clear and edge in the same cycle
        drive_pad(32'h0);
        clear_caps(32'hFFFF_FFFF);
        m_mask = 32'h1;
        bus_write(4'h8, 32'h1);
        @(negedge clk);
        pad_in = 32'h1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 4'hC; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        m_pad = 32'h1; m_cap_both = 32'h1; m_cap_rise = 32'h1;
        repeat (2) @(negedge clk);
        bus_read(4'hC, b, r, f, l);
        chk("R8 set wins both", b, 32'h1);
        chk("R8 set wins rise", r, 32'h1);
        chk("R8 irq held", 32'(irq_both), 32'h1);
        check_all("R8 after");

        finish_run();
    end
endmodule